// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block buffers received UART characters until software collects them, and produces the line status byte that software polls. A receiver front end hands over one character per write strobe, made of a data byte and three error tags (break, framing, parity). Every stored entry keeps its own tags. A read of the holding register returns the oldest character and removes it.

The status byte shows the following:
- the tags of the character that will be read next;
- an aggregate flag that is set while any tagged character remains anywhere in the queue;
- a sticky overrun flag;
- a data-ready flag;
- two transmitter-empty indications, taken from plain inputs.

Software reads the status byte first and then the holding register, so it learns the errors of a character before it takes that character. Reading the status byte never removes a character.

Top module: `rxq_status_unit`

## Requirements
- R1: After a synchronous reset the queue is empty, the tagged-entry count is zero and overrun is clear. The status byte then reads 0x60 while both transmitter inputs are 1, and the holding data reads 0x00.
- R2: Characters come out of the holding register in the order they were written. The queue holds up to DEPTH (64) characters.
- R3: Status bits 4, 3 and 2 show the break, framing and parity tags of the head entry. They read 0 while the queue is empty.
- R4: A status read (rdStatus) leaves the queue contents and the head entry unchanged. Only rdHold removes the head.
- R5: Status bit 7 is 1 while at least one stored entry carries any tag. It returns to 0 only when no tagged entry remains, and it stays exact when a write and a pop fall in the same cycle.
- R6: Status bit 0 is 1 when the queue holds at least one character and 0 when it is empty.
- R7: A write to a full queue, with no pop in the same cycle, discards the character and sets status bit 1. A status read clears bit 1 at the clock edge. If a new overrun falls in the same cycle as that read, the bit stays set.
- R8: A write to a full queue in the same cycle as a pop is accepted. It does not set overrun, and the queue remains full.
- R9: A character written with the break tag is stored with data 0x00, whatever the data byte supplied.
- R10: Status bit 5 equals txHoldEmpty. Status bit 6 is the AND of txHoldEmpty and txShiftEmpty.
- R11: rdHold on an empty queue returns 0x00 and leaves the queue empty and its pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrValid | input | 1 | Character write strobe from the receiver |
| wrData | input | 8 | Received data byte |
| wrBrk | input | 1 | Break tag of the incoming character |
| wrFrm | input | 1 | Framing-error tag of the incoming character |
| wrPar | input | 1 | Parity-error tag of the incoming character |
| rdHold | input | 1 | Holding-register read; pops the head at the clock edge |
| holdData | output | 8 | Head data byte, 0x00 when empty |
| rdStatus | input | 1 | Status read; clears overrun at the clock edge |
| txHoldEmpty | input | 1 | Transmit holding register empty |
| txShiftEmpty | input | 1 | Transmit shift register empty |
| statusWord | output | 8 | Line status byte |

## Verification
Two functions can fall in the same cycle: a push and a pop together, and an overrun together with the status read that clears overrun. The bench provokes both while the queue sits full. It writes with rdHold high to check that the character is accepted and that no overrun appears. It writes with rdStatus high to check that overrun survives its own clearing read. A long pseudo-random phase mixes tagged writes, pops and status reads at every fill level, with frequent simultaneous pushes and pops of tagged entries. Every cycle, the bench compares the status byte and the holding data against a queue model kept in the bench, which shows whether the tagged-entry count drifts.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rxqEntry_t;

  typedef struct packed {
    logic push;
    logic pop;
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrValid,
  input  logic                       inTagged,
  input  logic                       rdHold,
  input  logic                       rdStatus,
  input  logic                       headTagged,
  output rxqStrobe_t                 strobe,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic                       notEmpty,
  output logic                       anyErr,
  output logic                       overrun
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLV = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fill, errCount;
  logic full, empty, ovfEvent;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (fill == FULLV);
  assign empty = (fill == '0);

  always_comb begin
    strobe.pop  = rdHold & ~empty;
    strobe.push = wrValid & (~full | strobe.pop);
    ovfEvent    = wrValid & full & ~strobe.pop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      fill     <= '0;
      errCount <= '0;
      overrun  <= 1'b0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
      fill <= fill + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
      errCount <= errCount + CNT_W'(strobe.push & inTagged)
                           - CNT_W'(strobe.pop & headTagged);
      if (ovfEvent)      overrun <= 1'b1;
      else if (rdStatus) overrun <= 1'b0;
    end
  end

  assign wrAddr   = wrPtr;
  assign rdAddr   = rdPtr;
  assign notEmpty = ~empty;
  assign anyErr   = (errCount != '0);

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fill <= FULLV);
  p_err_within_fill_r5: assert property (@(posedge clk) disable iff (rst)
    errCount <= fill);
  p_status_no_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (rdStatus && !rdHold && !wrValid) |=> ($stable(rdPtr) && $stable(fill)));
  p_ovr_on_full_r7: assert property (@(posedge clk) disable iff (rst)
    (wrValid && full && !rdHold) |=> overrun);
  p_full_swap_r8: assert property (@(posedge clk) disable iff (rst)
    (wrValid && full && rdHold) |=> full);
  p_empty_read_r11: assert property (@(posedge clk) disable iff (rst)
    (rdHold && empty && !wrValid) |=> (empty && $stable(rdPtr)));
endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  rxqStrobe_t               strobe,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  rxqEntry_t                inEntry,
  output rxqEntry_t                headEntry
);
  rxqEntry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrAddr] <= inEntry;
  end

  assign headEntry = mem[rdAddr];
endmodule

// File: rtl/rxq_status_unit.sv
module rxq_status_unit
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       wrBrk,
  input  logic       wrFrm,
  input  logic       wrPar,
  input  logic       rdHold,
  output logic [7:0] holdData,
  input  logic       rdStatus,
  input  logic       txHoldEmpty,
  input  logic       txShiftEmpty,
  output logic [7:0] statusWord
);
  localparam int PTR_W = $clog2(DEPTH);

  rxqStrobe_t       strobe;
  rxqEntry_t        inEntry, headEntry;
  logic [PTR_W-1:0] wrAddr, rdAddr;
  logic notEmpty, anyErr, overrun, headTagged, inTagged;

  always_comb begin
    inEntry.brk  = wrBrk;
    inEntry.frm  = wrFrm;
    inEntry.par  = wrPar;
    inEntry.data = wrBrk ? '0 : wrData;
  end

  assign inTagged   = wrBrk | wrFrm | wrPar;
  assign headTagged = notEmpty & (headEntry.brk | headEntry.frm | headEntry.par);

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wrValid(wrValid), .inTagged(inTagged),
    .rdHold(rdHold), .rdStatus(rdStatus), .headTagged(headTagged),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .notEmpty(notEmpty), .anyErr(anyErr), .overrun(overrun)
  );

  rxq_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inEntry(inEntry), .headEntry(headEntry)
  );

  always_comb begin
    holdData      = notEmpty ? headEntry.data : 8'h00;
    statusWord[7] = anyErr;
    statusWord[6] = txHoldEmpty & txShiftEmpty;
    statusWord[5] = txHoldEmpty;
    statusWord[4] = notEmpty & headEntry.brk;
    statusWord[3] = notEmpty & headEntry.frm;
    statusWord[2] = notEmpty & headEntry.par;
    statusWord[1] = overrun;
    statusWord[0] = notEmpty;
  end

  p_break_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (statusWord[4]) |-> (holdData == 8'h00));
  p_err_implies_data_r5: assert property (@(posedge clk) disable iff (rst)
    statusWord[7] |-> statusWord[0]);
endmodule

// File: tb/test_rxq_status_unit.sv
module test_rxq_status_unit;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrValid = 0, wrBrk = 0, wrFrm = 0, wrPar = 0;
  logic rdHold = 0, rdStatus = 0, txHoldEmpty = 1, txShiftEmpty = 1;
  logic [7:0] wrData = 0;
  logic [7:0] holdData, statusWord;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [10:0] q[$];
  logic ovr = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;

  rxq_status_unit #(.DEPTH(DEPTH)) i_rxq_status_unit (
    .clk(clk), .rst(rst), .wrValid(wrValid), .wrData(wrData),
    .wrBrk(wrBrk), .wrFrm(wrFrm), .wrPar(wrPar), .rdHold(rdHold),
    .holdData(holdData), .rdStatus(rdStatus), .txHoldEmpty(txHoldEmpty),
    .txShiftEmpty(txShiftEmpty), .statusWord(statusWord)
  );

  function automatic logic [7:0] expStatus();
    int errs = 0;
    logic [2:0] tg = 3'b000;
    foreach (q[i]) if (q[i][10:8] != 3'b000) errs++;
    if (q.size() > 0) tg = q[0][10:8];
    return {errs != 0, txHoldEmpty & txShiftEmpty, txHoldEmpty, tg, ovr, q.size() > 0};
  endfunction

  function automatic logic [7:0] expHold();
    return (q.size() > 0) ? q[0][7:0] : 8'h00;
  endfunction

  task automatic cmp(input string lbl, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", lbl, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  task automatic step(input logic wr, input logic [7:0] d, input logic [2:0] tg,
                      input logic rh, input logic rs, input logic th, input logic ts,
                      input string lbl);
    logic mfull, mpop, mpush;
    @(negedge clk);
    wrValid = wr; wrData = d; wrBrk = tg[2]; wrFrm = tg[1]; wrPar = tg[0];
    rdHold = rh; rdStatus = rs; txHoldEmpty = th; txShiftEmpty = ts;
    #1;
    cmp({lbl, " status"}, statusWord, expStatus());
    cmp({lbl, " hold"}, holdData, expHold());
    @(posedge clk);
    mfull = (q.size() == DEPTH);
    mpop  = rh && (q.size() > 0);
    mpush = wr && (!mfull || mpop);
    if (mpop) void'(q.pop_front());
    if (mpush) q.push_back({tg, tg[2] ? 8'h00 : d});
    if (wr && mfull && !mpop) ovr = 1'b1;
    else if (rs) ovr = 1'b0;
  endtask

  task automatic idle(input string lbl);
    step(0, 8'h00, 3'b000, 0, 0, 1, 1, lbl);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    q.delete(); ovr = 0;
    // R1: reset state
    #1;
    cmp("R1 reset status", statusWord, 8'h60);
    cmp("R1 reset hold", holdData, 8'h00);
    idle("R1");

    // R10: transmitter inputs sweep
    for (int k = 0; k < 4; k++) step(0, 8'h00, 3'b000, 0, 0, k[0], k[1], "R10");

    // R11: hold read while empty, then a single round trip
    step(0, 8'h00, 3'b000, 1, 0, 1, 1, "R11");
    idle("R11");
    step(1, 8'h5A, 3'b000, 0, 0, 1, 1, "R11");
    step(0, 8'h00, 3'b000, 1, 0, 1, 1, "R11");
    idle("R11");

    // R6/R3/R9: fill to capacity with varied tags
    for (int i = 0; i < DEPTH; i++) begin
      logic [2:0] tg = (i % 4 == 3) ? 3'((i >> 2) + 1) : 3'b000;
      step(1, 8'(i * 37 + 5), tg, 0, 0, 1, 1, "R6");
    end
    idle("R6");

    // R7: overrun while full, set wins over a clearing read, then cleared
    step(1, 8'hEE, 3'b001, 0, 0, 1, 1, "R7");
    idle("R7");
    step(1, 8'hEF, 3'b000, 0, 1, 1, 1, "R7");
    step(0, 8'h00, 3'b000, 0, 1, 1, 1, "R7");
    idle("R7");

    // R8: push with pop while full
    step(1, 8'hC3, 3'b010, 1, 0, 1, 1, "R8");
    idle("R8");
    step(1, 8'h3C, 3'b000, 0, 0, 1, 1, "R8");
    idle("R8");
    step(0, 8'h00, 3'b000, 0, 1, 1, 1, "R8");

    // R2/R3/R4/R9: drain with interleaved status reads
    for (int n = 0; q.size() > 0; n++) begin
      string lbl = q[0][10] ? "R9" : (q[0][9:8] != 0) ? "R3" : "R2";
      if (n % 3 == 0) step(0, 8'h00, 3'b000, 0, 1, 1, 1, "R4");
      step(0, 8'h00, 3'b000, 1, 0, 1, 1, lbl);
    end
    idle("R5");
    step(0, 8'h00, 3'b000, 1, 0, 1, 1, "R11");
    idle("R11");

    // R5: break stored as zero, simultaneous tagged push/pop
    step(1, 8'hA5, 3'b100, 0, 0, 1, 1, "R9");
    step(1, 8'h11, 3'b001, 1, 0, 1, 1, "R5");
    step(1, 8'h22, 3'b000, 1, 0, 1, 1, "R5");
    step(0, 8'h00, 3'b000, 1, 0, 1, 1, "R5");
    idle("R5");

    // R5: long pseudo-random mix
    for (int c = 0; c < 6000; c++) begin
      logic [31:0] r = nextRand();
      logic rhBias = (c / 500) % 2 == 1;
      logic [2:0] tg = (r[5:4] == 2'b00) ? r[2:0] : 3'b000;
      logic rh = rhBias ? (r[9:8] != 2'b00) : (r[9:8] == 2'b00);
      step(r[6], r[23:16], tg, rh, r[12:10] == 3'b000, r[13], r[14], "R5");
    end
    while (q.size() > 0) step(0, 8'h00, 3'b000, 1, 0, 1, 1, "R5");
    step(0, 8'h00, 3'b000, 0, 1, 1, 1, "R7");
    idle("R5");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule